// File: doc/BRIEF.md
# Phase-Shifted Full-Bridge Gate Timing Generator

This block produces the switching pattern for an isolated full-bridge converter that uses phase-shift control: two gate signals for the leading leg, two for the lagging leg, and one for a clamp switch on the secondary side. All five come from one clock. Each bridge gate is nominally on for half of a switching period. Power is set only by how far the lagging leg runs behind the leading leg. A programmable dead time keeps both switches of a leg off around each commutation.

The clamp gate repeats every half period, so it runs at twice the bridge frequency. It turns on a programmable number of clocks before each rising edge of the rectified secondary voltage. That edge lines up with every leading-leg commutation, and the gate stays on until the lagging leg commutes. Period, phase, dead time and clamp lead are sampled only when the leading-leg period wraps. A fault or a dropped enable turns every gate off on the next clock edge. Switching resumes at a period boundary once the block is enabled and fault-free again.

Top module: `psfb_pwm_gen`

## Requirements
- R1: While reset is asserted all five gate outputs are low. Reset loads a period of 4 clocks and zero phase, dead time and clamp lead.
- R2: The period P is the period input with bit 0 cleared, raised to 4 if smaller. H = P/2. Gate outputs follow the period position k (0..P-1) one clock later. The leading high gate is on for D <= k < H and the leading low gate for k >= H + D, where D is the dead-time input. If D >= H, neither gate turns on.
- R3: The lagging gates follow the same rule as the leading gates, applied to position (k + P - S) mod P, where S is the effective phase.
- R4: S equals the phase input, limited to at most H. When S = 0 the lagging gates equal the leading gates and the clamp gate stays off.
- R5: The two gates of one leg are never high in the same cycle.
- R6: With j = k mod H and K the clamp-lead input, the clamp gate is on when S > 0 and either j < S or j + K >= H. It therefore repeats every H clocks.
- R7: Period, phase, dead-time and clamp-lead inputs are captured only in the cycle where k = P - 1. Changes at other times have no effect until then.
- R8: If fault is high or enable is low at a clock edge, all gate outputs are low after that edge.
- R9: After enable returns with no fault, the gates stay low until the next wrap (k = P - 1 to 0). They then resume from k = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request |
| fault | input | 1 | Fault shutdown, active high |
| periodIn | input | CNT_W | Bridge period in clocks |
| phaseIn | input | CNT_W | Lag of the lagging leg in clocks |
| deadIn | input | DEAD_W | Dead time in clocks |
| clampDlyIn | input | CNT_W | Clamp turn-on lead in clocks |
| gateLeadHi | output | 1 | Leading leg upper switch gate |
| gateLeadLo | output | 1 | Leading leg lower switch gate |
| gateLagHi | output | 1 | Lagging leg upper switch gate |
| gateLagLo | output | 1 | Lagging leg lower switch gate |
| gateClamp | output | 1 | Secondary clamp switch gate |

## Verification
The hardest case to reach is a settings change that arrives mid-period. The test must show that the old values govern the rest of that period and that the new phase preload lands exactly on the wrap. A second hard case is a fault or enable drop at an arbitrary point, followed by the wait for a boundary before gates resume. The stimulus changes all inputs at random cycles within each period and injects random fault pulses and enable gaps. Directed segments add clamped phase, zero phase, oversized dead time, odd and undersized periods, and a change made just after a wrap.

// File: rtl/psfb_pkg.sv
package psfb_pkg;
  typedef struct packed {
    logic load;   // capture new settings, restart counters
    logic drive;  // gate outputs may follow the timing
  } strobe_t;

  localparam int NUM_GATES  = 5;
  localparam int G_LEAD_HI  = 0;
  localparam int G_LEAD_LO  = 1;
  localparam int G_LAG_HI   = 2;
  localparam int G_LAG_LO   = 3;
  localparam int G_CLAMP    = 4;
  localparam int MIN_PERIOD = 4;
endpackage

// File: rtl/psfb_ctrl.sv
module psfb_ctrl
  import psfb_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    enable,
  input  logic    fault,
  input  logic    wrapNow,
  output strobe_t stb
);
  logic active;
  logic runOk;

  assign runOk     = enable && !fault;
  assign stb.load  = wrapNow;
  assign stb.drive = runOk && active;

  // active only becomes set on a period boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active <= 1'b0;
    else        active <= runOk && (active || wrapNow);
  end
endmodule

// File: rtl/psfb_datapath.sv
module psfb_datapath
  import psfb_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DEAD_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  strobe_t              stb,
  input  logic [CNT_W-1:0]     periodIn,
  input  logic [CNT_W-1:0]     phaseIn,
  input  logic [DEAD_W-1:0]    deadIn,
  input  logic [CNT_W-1:0]     clampDlyIn,
  output logic                 wrapNow,
  output logic [CNT_W-1:0]     shPeriodOut,
  output logic [CNT_W-1:0]     shPhaseOut,
  output logic [NUM_GATES-1:0] gateQ
);
  localparam int EXT_W = CNT_W + 1;
  localparam int NUM_LEGS = 2;
  localparam logic [CNT_W-1:0] P_MIN = CNT_W'(MIN_PERIOD);

  logic [CNT_W-1:0]  leadCnt, lagCnt;
  logic [CNT_W-1:0]  shPeriod, shHalf, shPhase, shDly;
  logic [DEAD_W-1:0] shDead;

  logic [CNT_W-1:0] evenPer, nxtPeriod, nxtHalf, nxtPhase;

  assign evenPer   = {periodIn[CNT_W-1:1], 1'b0};
  assign nxtPeriod = (evenPer < P_MIN) ? P_MIN : evenPer;
  assign nxtHalf   = nxtPeriod >> 1;
  assign nxtPhase  = (phaseIn > nxtHalf) ? nxtHalf : phaseIn;

  assign wrapNow     = (leadCnt == shPeriod - CNT_W'(1));
  assign shPeriodOut = shPeriod;
  assign shPhaseOut  = shPhase;

  // settings shadow and the two leg counters
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      leadCnt  <= '0;
      lagCnt   <= '0;
      shPeriod <= P_MIN;
      shHalf   <= P_MIN >> 1;
      shPhase  <= '0;
      shDly    <= '0;
      shDead   <= '0;
    end else if (stb.load) begin
      leadCnt  <= '0;
      lagCnt   <= (nxtPhase == '0) ? '0 : nxtPeriod - nxtPhase;
      shPeriod <= nxtPeriod;
      shHalf   <= nxtHalf;
      shPhase  <= nxtPhase;
      shDly    <= clampDlyIn;
      shDead   <= deadIn;
    end else begin
      leadCnt <= leadCnt + CNT_W'(1);
      lagCnt  <= (lagCnt == shPeriod - CNT_W'(1)) ? '0 : lagCnt + CNT_W'(1);
    end
  end

  // per-leg complementary gates with dead time
  logic [CNT_W-1:0]    legCnt [NUM_LEGS];
  logic [NUM_LEGS-1:0] hiRaw, loRaw;

  assign legCnt[0] = leadCnt;
  assign legCnt[1] = lagCnt;

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    assign hiRaw[g] = (EXT_W'(legCnt[g]) >= EXT_W'(shDead)) && (legCnt[g] < shHalf);
    assign loRaw[g] = (EXT_W'(legCnt[g]) >= EXT_W'(shHalf) + EXT_W'(shDead));
  end

  // clamp gate repeats every half period
  logic [CNT_W-1:0] halfPos;
  logic             clampRaw;

  assign halfPos  = (leadCnt < shHalf) ? leadCnt : leadCnt - shHalf;
  assign clampRaw = (shPhase != '0) &&
                    ((halfPos < shPhase) ||
                     (EXT_W'(halfPos) + EXT_W'(shDly) >= EXT_W'(shHalf)));

  logic [NUM_GATES-1:0] gateRaw;
  always_comb begin
    gateRaw            = '0;
    gateRaw[G_LEAD_HI] = hiRaw[0];
    gateRaw[G_LEAD_LO] = loRaw[0];
    gateRaw[G_LAG_HI]  = hiRaw[1];
    gateRaw[G_LAG_LO]  = loRaw[1];
    gateRaw[G_CLAMP]   = clampRaw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gateQ <= '0;
    else        gateQ <= stb.drive ? gateRaw : '0;
  end
endmodule

// File: rtl/psfb_pwm_gen.sv
module psfb_pwm_gen
  import psfb_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DEAD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              fault,
  input  logic [CNT_W-1:0]  periodIn,
  input  logic [CNT_W-1:0]  phaseIn,
  input  logic [DEAD_W-1:0] deadIn,
  input  logic [CNT_W-1:0]  clampDlyIn,
  output logic              gateLeadHi,
  output logic              gateLeadLo,
  output logic              gateLagHi,
  output logic              gateLagLo,
  output logic              gateClamp
);
  strobe_t              stb;
  logic                 wrapNow;
  logic [CNT_W-1:0]     shPeriod, shPhase;
  logic [NUM_GATES-1:0] gateQ;

  psfb_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .fault   (fault),
    .wrapNow (wrapNow),
    .stb     (stb)
  );

  psfb_datapath #(.CNT_W(CNT_W), .DEAD_W(DEAD_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .stb         (stb),
    .periodIn    (periodIn),
    .phaseIn     (phaseIn),
    .deadIn      (deadIn),
    .clampDlyIn  (clampDlyIn),
    .wrapNow     (wrapNow),
    .shPeriodOut (shPeriod),
    .shPhaseOut  (shPhase),
    .gateQ       (gateQ)
  );

  assign gateLeadHi = gateQ[G_LEAD_HI];
  assign gateLeadLo = gateQ[G_LEAD_LO];
  assign gateLagHi  = gateQ[G_LAG_HI];
  assign gateLagLo  = gateQ[G_LAG_LO];
  assign gateClamp  = gateQ[G_CLAMP];
endmodule

// File: rtl/psfb_pwm_chk.sv
module psfb_pwm_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             fault,
  input logic             wrapNow,
  input logic [CNT_W-1:0] shPeriod,
  input logic [CNT_W-1:0] shPhase,
  input logic             gateLeadHi,
  input logic             gateLeadLo,
  input logic             gateLagHi,
  input logic             gateLagLo,
  input logic             gateClamp
);
  logic anyGate;
  assign anyGate = gateLeadHi || gateLeadLo || gateLagHi || gateLagLo || gateClamp;

  // R1: outputs low while reset is held
  always_comb begin
    if (rst_n === 1'b0) begin
      p_reset_low_r1: assert (!anyGate);
    end
  end

  // R5: never both switches of one leg
  p_lead_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(gateLeadHi && gateLeadLo));
  p_lag_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(gateLagHi && gateLagLo));

  // R8: shutdown one edge after fault or enable loss
  p_kill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault || !enable) |=> !anyGate);

  // R7: captured settings change only on a wrap
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wrapNow |=> ($stable(shPeriod) && $stable(shPhase)));

  // R4: zero phase aligns legs and silences clamp
  p_zero_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (shPhase == '0) |=> (gateLeadHi == gateLagHi && gateLeadLo == gateLagLo && !gateClamp));
endmodule

bind psfb_pwm_gen psfb_pwm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .fault      (fault),
  .wrapNow    (wrapNow),
  .shPeriod   (shPeriod),
  .shPhase    (shPhase),
  .gateLeadHi (gateLeadHi),
  .gateLeadLo (gateLeadLo),
  .gateLagHi  (gateLagHi),
  .gateLagLo  (gateLagLo),
  .gateClamp  (gateClamp)
);

// File: tb/sim_psfb_pwm_gen.sv
`timescale 1ns/1ps
module sim_psfb_pwm_gen;
  localparam int CNT_W  = 16;
  localparam int DEAD_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic fault = 1'b0;
  logic [CNT_W-1:0]  periodIn = '0;
  logic [CNT_W-1:0]  phaseIn = '0;
  logic [DEAD_W-1:0] deadIn = '0;
  logic [CNT_W-1:0]  clampDlyIn = '0;
  logic gateLeadHi, gateLeadLo, gateLagHi, gateLagLo, gateClamp;

  always #4 clk = ~clk;  // 125 MHz

  psfb_pwm_gen #(.CNT_W(CNT_W), .DEAD_W(DEAD_W)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .fault(fault),
    .periodIn(periodIn), .phaseIn(phaseIn), .deadIn(deadIn), .clampDlyIn(clampDlyIn),
    .gateLeadHi(gateLeadHi), .gateLeadLo(gateLeadLo),
    .gateLagHi(gateLagHi), .gateLagLo(gateLagLo), .gateClamp(gateClamp)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // reference model state
  int mc, mP, mH, mS, mD, mK;
  bit mActive;
  bit r7Mode = 0;
  string killTag = "R9";
  bit phaseSpecial = 0;

  function automatic logic [4:0] modelGates(int k);
    logic [4:0] g;
    int lk, j;
    g = '0;
    lk = (k + mP - mS) % mP;
    j = k % mH;
    g[0] = (k >= mD) && (k < mH);
    g[1] = (k >= mH + mD);
    g[2] = (lk >= mD) && (lk < mH);
    g[3] = (lk >= mH + mD);
    g[4] = (mS > 0) && ((j < mS) || (j + mK >= mH));
    return g;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    mc = 0; mP = 4; mH = 2; mS = 0; mD = 0; mK = 0; mActive = 0;
  endtask

  task automatic step();
    logic [4:0] nx;
    bit runOk, wrap, driven;
    int p, ph;
    string leadTag, lagTag;
    runOk  = enable && !fault;
    driven = runOk && mActive;
    nx = driven ? modelGates(mc) : 5'b0;
    killTag = !runOk ? "R8" : "R9";
    leadTag = !driven ? killTag : (r7Mode ? "R7" : "R2");
    lagTag  = !driven ? killTag : ((mS == 0 || phaseSpecial) ? "R4" : "R3");
    wrap = (mc == mP - 1);
    mActive = runOk && (mActive || wrap);
    if (wrap) begin
      p = int'(periodIn) & ~1;
      if (p < 4) p = 4;
      mP = p; mH = p / 2;
      ph = int'(phaseIn);
      mS = (ph > mH) ? mH : ph;
      mD = int'(deadIn); mK = int'(clampDlyIn);
      mc = 0;
    end else begin
      mc++;
    end
    @(posedge clk);
    @(negedge clk);
    check(leadTag, {gateLeadHi, gateLeadLo}, {nx[0], nx[1]});
    check(lagTag, {gateLagHi, gateLagLo}, {nx[2], nx[3]});
    check(driven ? "R6" : killTag, gateClamp, nx[4]);
    check("R5", {gateLeadHi && gateLeadLo, gateLagHi && gateLagLo}, 0);
  endtask

  task automatic setCfg(int p, int s, int d, int k);
    periodIn = CNT_W'(p); phaseIn = CNT_W'(s);
    deadIn = DEAD_W'(d); clampDlyIn = CNT_W'(k);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic runToWrap();
    while (mc != mP - 1) step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", {gateLeadHi, gateLeadLo, gateLagHi, gateLagLo, gateClamp}, 0);
    rst_n = 1'b1;

    // R2/R3/R6 basic pattern
    setCfg(8, 2, 1, 1);
    enable = 1'b1;
    run(40);
    // R6: wider clamp lead, larger period
    setCfg(20, 3, 2, 4);
    run(60);
    // R4: zero phase, then phase above half period
    phaseSpecial = 1;
    setCfg(12, 0, 1, 2);
    run(40);
    setCfg(12, 100, 1, 2);
    run(40);
    phaseSpecial = 0;
    // R2: dead time not smaller than half period
    setCfg(8, 2, 5, 1);
    run(30);
    // R2: odd and undersized periods
    setCfg(9, 3, 0, 1);
    run(30);
    setCfg(2, 1, 0, 0);
    run(20);
    // R7: change right after a wrap; old values hold until next wrap
    setCfg(16, 4, 1, 2);
    run(40);
    runToWrap();
    step();
    r7Mode = 1;
    setCfg(24, 7, 2, 3);
    run(40);
    r7Mode = 0;
    // R8: fault pulse mid-period, R9: restart on boundary
    step(); step(); step();
    fault = 1'b1; step(); fault = 1'b0;
    run(40);
    enable = 1'b0; run(5); enable = 1'b1;
    run(60);

    // random segments
    for (int seg = 0; seg < 80; seg++) begin
      int len;
      len = 20 + int'($urandom_range(0, 120));
      for (int i = 0; i < len; i++) begin
        if ($urandom_range(0, 29) == 0) begin
          int p;
          p = int'($urandom_range(3, 40));
          setCfg(p, int'($urandom_range(0, p)), int'($urandom_range(0, 5)),
                 int'($urandom_range(0, p / 2)));
        end
        fault  = ($urandom_range(0, 99) < 2);
        if ($urandom_range(0, 199) == 0) enable = ~enable;
        step();
      end
      enable = 1'b1;
      fault  = 1'b0;
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule